// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block recovers characters from an asynchronous serial line. A one-cycle enable, running at sixteen times the bit rate, paces a small controller that qualifies start bits, walks through data, optional parity and stop positions, and strobes a datapath. The datapath assembles 7-, 8- or 9-bit characters, checks parity and framing, spots line breaks and hands completed characters to a single receive buffer with a full flag.

Errors are gathered into four sticky flags that one status read clears, plus a combined error output. In attention mode the receiver drops characters until one arrives with its ninth bit set, which is useful for addressed multi-drop links. A loopback setting feeds the receiver from a local transmitter output in place of the pin.

Top module: `serial_rx_core`

## Requirements
- R1: A falling edge starts a frame only if the line is still low at the eighth oversample tick after it; a low pulse shorter than that delivers no character and sets no flag.
- R2: charLen selects framing: 00 = 8 data bits, 01 = 7 data bits, 10 = 9 data bits, 11 = loopback with 9 data bits. Data arrive least significant bit first; rxData holds bits 0..7 (bit 7 reads 0 in 7-bit mode) and rxBit9 holds the ninth bit of the last buffered 9-bit character.
- R3: With parEn = 1 in 7- or 8-bit mode a parity bit follows the data; parSel 00 = odd, 01 = even, 10 = always 1, 11 = always 0. A mismatch sets parErr while the character is still delivered. In 9-bit modes no parity bit is expected and parEn has no effect.
- R4: bufFull rises when a character is placed in the buffer and falls after a one-cycle bufRead pulse.
- R5: A character completing while bufFull is set raises ovrErr and is discarded; rxData keeps the earlier character.
- R6: A low stop bit sets frmErr and raises lineHeld, which stays high until the line returns high.
- R7: A frame that is low at every data, parity and stop position sets brkErr (and frmErr).
- R8: ovrErr, frmErr, parErr and brkErr stay set until a one-cycle statRead pulse clears them all; anyErr is high whenever any of them is set. A new error in the same cycle as the read wins.
- R9: attnSet raises attnMode. While attnMode is high, characters with ninth bit 0 are dropped without setting bufFull; a character with ninth bit 1 is delivered and clears attnMode.
- R10: In loopback mode the receiver takes loopTx and ignores rxPin; otherwise it takes rxPin and ignores loopTx.
- R11: After reset bufFull, all error flags, attnMode and lineHeld are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversample enable, 16 per bit period |
| rxPin | input | 1 | Serial line from the pin |
| loopTx | input | 1 | Local transmitter output for loopback |
| charLen | input | 2 | Framing select (R2) |
| parEn | input | 1 | Parity enable |
| parSel | input | 2 | Parity kind (R3) |
| bufRead | input | 1 | One-cycle buffer read strobe |
| statRead | input | 1 | One-cycle status read strobe, clears error flags |
| attnSet | input | 1 | Enter attention mode |
| rxData | output | 8 | Buffered character, bits 0..7 |
| rxBit9 | output | 1 | Ninth bit of the buffered character |
| bufFull | output | 1 | Buffer holds an unread character |
| ovrErr | output | 1 | Sticky overrun flag |
| frmErr | output | 1 | Sticky framing flag |
| parErr | output | 1 | Sticky parity flag |
| brkErr | output | 1 | Sticky break flag |
| anyErr | output | 1 | OR of the four sticky flags |
| attnMode | output | 1 | Attention mode active |
| lineHeld | output | 1 | Framing error seen, line not yet high again |

## Verification
The bench sweeps both short lengths across every parity kind and many data values, sending each character with correct and then with flipped parity; a receiver that computed odd and even the wrong way round, or shifted the data by a bit, would corrupt rxData or raise parErr on good frames. It sends a short low glitch that a receiver sampling too early would turn into a phantom character, and runs one frame at a slower oversample rate to catch logic that counts clocks instead of ticks. Back-to-back unread characters, a frame with a low stop bit and an all-zero break check that overrun keeps the old data and that framing and break are told apart, with lineHeld released only when the line goes high. Attention-mode filtering and loopback with a quiet pin close the set; a design that delivered address-less characters or listened to the pin in loopback would set bufFull where it must not.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef struct packed {
    logic frameStart;
    logic dataShift;
    logic parSample;
    logic stopSample;
    logic bitVal;
  } rx_strobe_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_t;

  localparam logic [1:0] LEN_8    = 2'b00;
  localparam logic [1:0] LEN_7    = 2'b01;
  localparam logic [1:0] LEN_9    = 2'b10;
  localparam logic [1:0] LEN_LOOP = 2'b11;
endpackage

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       lineIn,
  input  logic [1:0] charLen,
  input  logic       parEn,
  output rx_strobe_t strb,
  output logic       lineHeld
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

  rx_state_t state, stateNext;
  logic [CNT_W-1:0] ovsCnt, ovsNext;
  logic [3:0] bitCnt, bitNext;
  logic [3:0] lastBit;
  logic parOn;

  always_comb begin
    case (charLen)
      LEN_7:   lastBit = 4'd6;
      LEN_8:   lastBit = 4'd7;
      default: lastBit = 4'd8;
    endcase
  end
  assign parOn = parEn & ~charLen[1];

  always_comb begin
    stateNext = state;
    ovsNext = ovsCnt;
    bitNext = bitCnt;
    strb = '0;
    strb.bitVal = lineIn;
    case (state)
      RX_IDLE: if (tick && !lineIn) begin
        stateNext = RX_START;
        ovsNext = '0;
      end
      RX_START: if (tick) begin
        if (ovsCnt == MID_CNT) begin
          ovsNext = '0;
          bitNext = '0;
          if (!lineIn) begin
            stateNext = RX_DATA;
            strb.frameStart = 1'b1;
          end else begin
            stateNext = RX_IDLE;
          end
        end else begin
          ovsNext = ovsCnt + 1'b1;
        end
      end
      RX_DATA: if (tick) begin
        if (ovsCnt == LAST_CNT) begin
          ovsNext = '0;
          strb.dataShift = 1'b1;
          if (bitCnt == lastBit) stateNext = parOn ? RX_PAR : RX_STOP;
          else bitNext = bitCnt + 1'b1;
        end else begin
          ovsNext = ovsCnt + 1'b1;
        end
      end
      RX_PAR: if (tick) begin
        if (ovsCnt == LAST_CNT) begin
          ovsNext = '0;
          strb.parSample = 1'b1;
          stateNext = RX_STOP;
        end else begin
          ovsNext = ovsCnt + 1'b1;
        end
      end
      RX_STOP: if (tick) begin
        if (ovsCnt == LAST_CNT) begin
          ovsNext = '0;
          strb.stopSample = 1'b1;
          stateNext = lineIn ? RX_IDLE : RX_HOLD;
        end else begin
          ovsNext = ovsCnt + 1'b1;
        end
      end
      RX_HOLD: if (lineIn) stateNext = RX_IDLE;
      default: stateNext = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      ovsCnt <= '0;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      ovsCnt <= ovsNext;
      bitCnt <= bitNext;
    end
  end

  assign lineHeld = (state == RX_HOLD);
endmodule

// File: rtl/serial_rx_dp.sv
module serial_rx_dp
  import serial_rx_pkg::*;
#(
  parameter int MAX_BITS = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  rx_strobe_t strb,
  input  logic [1:0] charLen,
  input  logic       parEn,
  input  logic [1:0] parSel,
  input  logic       bufRead,
  input  logic       statRead,
  input  logic       attnSet,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       bufFull,
  output logic       ovrErr,
  output logic       frmErr,
  output logic       parErr,
  output logic       brkErr,
  output logic       attnMode
);
  logic [MAX_BITS-1:0] shiftReg;
  logic [8:0] aligned;
  logic parBitQ, allLow;
  logic nineBit, dataPar, expPar, parBad, stopBad, isBreak, bit9, keep, deliver, overrun;
  logic clrFlags;

  assign nineBit = charLen[1];

  always_comb begin
    case (charLen)
      LEN_7:   aligned = {2'b00, shiftReg[MAX_BITS-1:2]};
      LEN_8:   aligned = {1'b0, shiftReg[MAX_BITS-1:1]};
      default: aligned = shiftReg;
    endcase
  end

  assign dataPar = ^aligned[7:0];
  always_comb begin
    case (parSel)
      2'b00:   expPar = ~dataPar;
      2'b01:   expPar = dataPar;
      2'b10:   expPar = 1'b1;
      default: expPar = 1'b0;
    endcase
  end

  assign parBad  = parEn & ~nineBit & (parBitQ != expPar);
  assign stopBad = ~strb.bitVal;
  assign isBreak = allLow & ~strb.bitVal;
  assign bit9    = nineBit & aligned[8];
  assign keep    = ~attnMode | bit9;
  assign deliver = strb.stopSample & keep & ~bufFull;
  assign overrun = strb.stopSample & keep & bufFull;
  assign clrFlags = statRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBitQ  <= 1'b0;
      allLow   <= 1'b1;
    end else if (strb.frameStart) begin
      shiftReg <= '0;
      allLow   <= 1'b1;
    end else if (strb.dataShift) begin
      shiftReg <= {strb.bitVal, shiftReg[MAX_BITS-1:1]};
      allLow   <= allLow & ~strb.bitVal;
    end else if (strb.parSample) begin
      parBitQ  <= strb.bitVal;
      allLow   <= allLow & ~strb.bitVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxBit9  <= 1'b0;
      bufFull <= 1'b0;
    end else if (deliver) begin
      rxData  <= aligned[7:0];
      rxBit9  <= bit9;
      bufFull <= 1'b1;
    end else if (bufRead) begin
      bufFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovrErr <= 1'b0;
      frmErr <= 1'b0;
      parErr <= 1'b0;
      brkErr <= 1'b0;
    end else begin
      ovrErr <= (ovrErr & ~clrFlags) | overrun;
      frmErr <= (frmErr & ~clrFlags) | (strb.stopSample & stopBad);
      parErr <= (parErr & ~clrFlags) | (strb.stopSample & parBad);
      brkErr <= (brkErr & ~clrFlags) | (strb.stopSample & isBreak);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) attnMode <= 1'b0;
    else if (attnSet) attnMode <= 1'b1;
    else if (strb.stopSample && bit9) attnMode <= 1'b0;
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int MAX_BITS = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxPin,
  input  logic       loopTx,
  input  logic [1:0] charLen,
  input  logic       parEn,
  input  logic [1:0] parSel,
  input  logic       bufRead,
  input  logic       statRead,
  input  logic       attnSet,
  output logic [7:0] rxData,
  output logic       rxBit9,
  output logic       bufFull,
  output logic       ovrErr,
  output logic       frmErr,
  output logic       parErr,
  output logic       brkErr,
  output logic       anyErr,
  output logic       attnMode,
  output logic       lineHeld
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic rawLine, lineSync, stopStb;
  rx_strobe_t strb;

  assign rawLine = (charLen == LEN_LOOP) ? loopTx : rxPin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], rawLine};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  serial_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick16), .lineIn(lineSync),
    .charLen(charLen), .parEn(parEn), .strb(strb), .lineHeld(lineHeld)
  );

  serial_rx_dp #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .charLen(charLen), .parEn(parEn),
    .parSel(parSel), .bufRead(bufRead), .statRead(statRead), .attnSet(attnSet),
    .rxData(rxData), .rxBit9(rxBit9), .bufFull(bufFull), .ovrErr(ovrErr),
    .frmErr(frmErr), .parErr(parErr), .brkErr(brkErr), .attnMode(attnMode)
  );

  assign stopStb = strb.stopSample;
  assign anyErr = ovrErr | frmErr | parErr | brkErr;
endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker (
  input logic       clk,
  input logic       rstN,
  input logic       bufRead,
  input logic       statRead,
  input logic       attnSet,
  input logic       bufFull,
  input logic       anyErr,
  input logic [7:0] rxData,
  input logic       attnMode,
  input logic       lineHeld,
  input logic       lineSync,
  input logic       stopStb
);
  // R8: a status read with no frame ending clears every flag
  p_flags_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statRead && !stopStb) |=> !anyErr);

  // R4: a buffer read with no frame ending empties the buffer
  p_buf_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && !stopStb) |=> !bufFull);

  // R4: the buffer only fills at the end of a frame
  p_buf_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!bufFull && !stopStb) |=> !bufFull);

  // R5: a frame ending into a full buffer leaves the data alone
  p_ovr_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stopStb && bufFull) |=> $stable(rxData));

  // R6: a high line releases the held state
  p_held_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lineHeld && lineSync) |=> !lineHeld);

  // R9: attention mode persists until a frame ends
  p_attn_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (attnMode && !stopStb) |=> attnMode);

  // R9: attention mode is entered on request
  p_attn_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    attnSet |=> attnMode);
endmodule

bind serial_rx_core serial_rx_checker u_chk (
  .clk(clk), .rstN(rstN), .bufRead(bufRead), .statRead(statRead),
  .attnSet(attnSet), .bufFull(bufFull), .anyErr(anyErr), .rxData(rxData),
  .attnMode(attnMode), .lineHeld(lineHeld), .lineSync(lineSync), .stopStb(stopStb)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxPin = 1'b1;
  logic loopTx = 1'b1;
  logic [1:0] charLen = 2'b00;
  logic parEn = 1'b0;
  logic [1:0] parSel = 2'b00;
  logic bufRead = 1'b0, statRead = 1'b0, attnSet = 1'b0;
  logic [7:0] rxData;
  logic rxBit9, bufFull, ovrErr, frmErr, parErr, brkErr, anyErr, attnMode, lineHeld;

  int total = 0;
  int fails = 0;
  int tickDiv = 1;
  int tickCnt = 0;
  bit done = 1'b0;

  serial_rx_core i_serial_rx_core (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxPin(rxPin), .loopTx(loopTx),
    .charLen(charLen), .parEn(parEn), .parSel(parSel), .bufRead(bufRead),
    .statRead(statRead), .attnSet(attnSet), .rxData(rxData), .rxBit9(rxBit9),
    .bufFull(bufFull), .ovrErr(ovrErr), .frmErr(frmErr), .parErr(parErr),
    .brkErr(brkErr), .anyErr(anyErr), .attnMode(attnMode), .lineHeld(lineHeld)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (tickCnt >= tickDiv - 1) begin
      tickCnt <= 0;
      tick16 <= 1'b1;
    end else begin
      tickCnt <= tickCnt + 1;
      tick16 <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic driveBit(input logic v);
    if (charLen == 2'b11) loopTx = v;
    else rxPin = v;
    repeat (16 * tickDiv) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nData, input bit withPar,
                           input logic pBit, input logic stopV);
    driveBit(1'b0);
    for (int i = 0; i < nData; i++) driveBit(d[i]);
    if (withPar) driveBit(pBit);
    driveBit(stopV);
    if (stopV) driveBit(1'b1);
  endtask

  task automatic pulseBufRead();
    bufRead = 1'b1;
    @(negedge clk);
    bufRead = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseStatRead();
    statRead = 1'b1;
    @(negedge clk);
    statRead = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic parityFor(input logic [7:0] d, input logic [1:0] sel);
    logic ones;
    ones = ^d;
    case (sel)
      2'b00: return ~ones;
      2'b01: return ones;
      2'b10: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [8:0] d;
    logic [7:0] mask;
    int nBits;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk("R11 bufFull", int'(bufFull), 0);
    chk("R11 anyErr", int'(anyErr), 0);
    chk("R11 attnMode", int'(attnMode), 0);
    chk("R11 lineHeld", int'(lineHeld), 0);

    // R2/R3: short lengths, all parity kinds, good then bad parity
    for (int len = 0; len < 2; len++) begin
      charLen = 2'(len);
      nBits = (len == 1) ? 7 : 8;
      mask = (len == 1) ? 8'h7F : 8'hFF;
      for (int sel = 0; sel < 4; sel++) begin
        parSel = 2'(sel);
        for (int pe = 0; pe < 2; pe++) begin
          parEn = 1'(pe);
          for (int k = 0; k < 5; k++) begin
            d = 9'((k * 77 + sel * 29 + len * 13 + 5) & 8'hFF);
            sendFrame(d, nBits, pe == 1, parityFor(d[7:0] & mask, parSel), 1'b1);
            chk("R2 data", int'(rxData), int'(d[7:0] & mask));
            chk("R4 bufFull set", int'(bufFull), 1);
            chk("R3 good parity", int'(parErr), 0);
            pulseBufRead();
            chk("R4 bufFull cleared", int'(bufFull), 0);
          end
          if (pe == 1) begin
            d = 9'(8'hA6 & mask);
            sendFrame(d, nBits, 1'b1, ~parityFor(d[7:0], parSel), 1'b1);
            chk("R3 bad parity flagged", int'(parErr), 1);
            chk("R8 anyErr", int'(anyErr), 1);
            chk("R3 data still delivered", int'(rxData), int'(d[7:0]));
            pulseBufRead();
            pulseStatRead();
            chk("R8 cleared by status read", int'(anyErr), 0);
          end
        end
      end
    end

    // R2/R3: 9-bit frames, parity enable has no effect
    charLen = 2'b10;
    parEn = 1'b1;
    parSel = 2'b00;
    for (int k = 0; k < 6; k++) begin
      d = 9'((k * 101 + 3) & 9'h1FF);
      sendFrame(d, 9, 1'b0, 1'b0, 1'b1);
      chk("R2 nine-bit data", int'(rxData), int'(d[7:0]));
      chk("R2 ninth bit", int'(rxBit9), int'(d[8]));
      chk("R3 no parity in nine-bit", int'(anyErr), 0);
      pulseBufRead();
    end
    parEn = 1'b0;

    // R1: slower tick rate still lands on bit centres
    charLen = 2'b00;
    tickDiv = 3;
    repeat (6) @(negedge clk);
    sendFrame(9'h0C3, 8, 1'b0, 1'b0, 1'b1);
    chk("R1 slow tick data", int'(rxData), 8'hC3);
    pulseBufRead();
    tickDiv = 1;
    repeat (6) @(negedge clk);

    // R1: short glitch rejected
    rxPin = 1'b0;
    repeat (4) @(negedge clk);
    rxPin = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1 glitch no char", int'(bufFull), 0);
    chk("R1 glitch no error", int'(anyErr), 0);
    sendFrame(9'h05A, 8, 1'b0, 1'b0, 1'b1);
    chk("R1 frame after glitch", int'(rxData), 8'h5A);

    // R5: overrun keeps first character
    sendFrame(9'h0F0, 8, 1'b0, 1'b0, 1'b1);
    chk("R5 overrun flagged", int'(ovrErr), 1);
    chk("R5 old data kept", int'(rxData), 8'h5A);
    chk("R8 anyErr on overrun", int'(anyErr), 1);
    pulseBufRead();
    pulseStatRead();
    chk("R8 overrun cleared", int'(ovrErr), 0);

    // R6: framing error, not a break
    sendFrame(9'h055, 8, 1'b0, 1'b0, 1'b0);
    repeat (32) @(negedge clk);
    chk("R6 framing flagged", int'(frmErr), 1);
    chk("R7 not a break", int'(brkErr), 0);
    chk("R6 lineHeld while low", int'(lineHeld), 1);
    rxPin = 1'b1;
    repeat (8) @(negedge clk);
    chk("R6 lineHeld released", int'(lineHeld), 0);
    pulseBufRead();
    pulseStatRead();

    // R7: break
    sendFrame(9'h000, 8, 1'b0, 1'b0, 1'b0);
    repeat (32) @(negedge clk);
    chk("R7 break flagged", int'(brkErr), 1);
    chk("R7 framing with break", int'(frmErr), 1);
    chk("R6 lineHeld on break", int'(lineHeld), 1);
    rxPin = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 lineHeld after break", int'(lineHeld), 0);
    pulseBufRead();
    pulseStatRead();
    chk("R8 all cleared", int'(anyErr), 0);

    // R9: attention mode
    charLen = 2'b10;
    attnSet = 1'b1;
    @(negedge clk);
    attnSet = 1'b0;
    chk("R9 attn set", int'(attnMode), 1);
    sendFrame(9'h033, 9, 1'b0, 1'b0, 1'b1);
    chk("R9 dropped without ninth bit", int'(bufFull), 0);
    chk("R9 still in attn", int'(attnMode), 1);
    sendFrame(9'h1A7, 9, 1'b0, 1'b0, 1'b1);
    chk("R9 address delivered", int'(bufFull), 1);
    chk("R9 address data", int'(rxData), 8'hA7);
    chk("R9 address ninth bit", int'(rxBit9), 1);
    chk("R9 attn cleared", int'(attnMode), 0);
    pulseBufRead();

    // R10: loopback, pin held quiet
    rxPin = 1'b1;
    loopTx = 1'b1;
    charLen = 2'b11;
    repeat (6) @(negedge clk);
    sendFrame(9'h13C, 9, 1'b0, 1'b0, 1'b1);
    chk("R10 loopback data", int'(rxData), 8'h3C);
    chk("R10 loopback ninth bit", int'(rxBit9), 1);
    pulseBufRead();
    // R10: in normal mode loopTx is ignored
    charLen = 2'b00;
    repeat (6) @(negedge clk);
    loopTx = 1'b0;
    repeat (400) @(negedge clk);
    loopTx = 1'b1;
    chk("R10 loopTx ignored", int'(bufFull), 0);
    chk("R10 loopTx no error", int'(anyErr), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule